// File: doc/BRIEF.md
# Printer Port Host Register Block

This block is the host-facing register set of a byte-wide printer port. A host reaches three registers (a data byte, a status byte and a control byte) through a small synchronous bus with a single-cycle access strobe. Writes to the control register drive a simple printer handshake model. Taking the initialise bit low puts the status back to its idle pattern. A rising strobe bit, with the select bit high, sends the last written data byte to the attached sink. With select high and strobe low, the block can latch a pending interrupt.

Reads of the status register advance a small acknowledge/busy sequence, so polling host software sees the pattern a simple printer would produce. Each status read also clears the pending interrupt. The interrupt pin is a registered copy of the pending flag. Each sent byte appears on `emit_data`, qualified by a one-cycle `emit_valid` pulse. When the direction bit is set, the block captures a peripheral-side byte into a read latch, and a data read returns that latch.

Top module: `lpt_host_regs`

## Requirements
- R1: The low three address bits pick the register: 0 is data, 1 is status and 2 is control. Reads of offsets 3 to 7 return 0xFF. Writes to offset 1 or to offsets 3 to 7 change no register.
- R2: Every control write stores the written value with bits 7 and 6 forced to 1, so a control read always shows both bits set.
- R3: A control write with bit 2 (initialise) at 0 sets status to 0xD8 (bits 7, 6, 4 and 3).
- R4: A control write with bit 2 set, bit 3 (select) set and bit 0 (strobe) set clears status bit 7 (busy). If the previously stored control value had strobe at 0, the same write sends the data byte. A sent byte shows on `emit_data`, with `emit_valid` high for exactly the one cycle after the write. A write with select at 0 sends nothing.
- R5: A control write with bit 2 set, select set and strobe at 0 sets the pending interrupt when the previously stored control value had bit 4 (interrupt enable) set. The bit 4 of the value being written does not matter here. `irq` follows the pending flag from the cycle after the access.
- R6: A status read clears the pending interrupt, so `irq` is low in the cycle after the read.
- R7: A status read returns the current status. After the read, the status changes only if busy (bit 7) is 0 and the stored control strobe is 0. In that case ack (bit 6) is cleared when it is set. When ack is clear, both ack and busy are set instead.
- R8: A data read returns the read latch when control bit 5 (direction) is 1, and the last written data byte otherwise. While direction is 1, the read latch captures `port_din` on every clock.
- R9: Reset sets the written data byte and the read latch to 0xFF, status to 0xD9, control to 0xCC, and the pending interrupt, `irq` and `emit_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Single-cycle access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| port_din | input | 8 | Peripheral-side byte for the read latch |
| irq | output | 1 | Interrupt request |
| emit_valid | output | 1 | One-cycle pulse marking a sent byte |
| emit_data | output | 8 | Byte sent to the printer sink |

## Verification
The status walk only advances when busy is already clear and the stored strobe is low. Reaching that state takes a strobe-high control write to drop busy, followed by a strobe-low write that keeps select and initialise high. Only after that do successive status reads pass through 0x58, 0x18 and 0xD8 and then stop. The interrupt corner needs two control writes in a row: the first stores the enable bit, and the second (even one that clears enable) raises the interrupt from the stored value.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
    localparam int BYTE_W = 8;
    localparam int OFS_W  = 3;

    // control bit positions
    localparam int CTL_STROBE = 0;
    localparam int CTL_INIT   = 2;
    localparam int CTL_SELECT = 3;
    localparam int CTL_IRQEN  = 4;
    localparam int CTL_DIR    = 5;

    // status bit positions
    localparam int ST_ACK  = 6;
    localparam int ST_BUSY = 7;

    localparam logic [BYTE_W-1:0] STATUS_RST    = 8'hD9;
    localparam logic [BYTE_W-1:0] STATUS_IDLE   = 8'hD8;
    localparam logic [BYTE_W-1:0] CONTROL_RST   = 8'hCC;
    localparam logic [BYTE_W-1:0] CONTROL_FORCE = 8'hC0;
    localparam logic [BYTE_W-1:0] DATA_RST      = 8'hFF;
    localparam logic [BYTE_W-1:0] OPEN_READ     = 8'hFF;

    typedef enum logic [OFS_W-1:0] {
        OFS_DATA    = 3'd0,
        OFS_STATUS  = 3'd1,
        OFS_CONTROL = 3'd2
    } ofs_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dataw;
        logic [BYTE_W-1:0] datar;
        logic [BYTE_W-1:0] status;
        logic [BYTE_W-1:0] control;
        logic              pend;
        logic              irq;
        logic              emit_valid;
        logic [BYTE_W-1:0] emit_data;
    } regs_t;
endpackage

// File: rtl/lpt_ctrl_write.sv
module lpt_ctrl_write
    import lpt_pkg::*;
(
    input  logic [BYTE_W-1:0] wdata,
    input  logic              prev_strobe,
    input  logic              prev_irqen,
    input  logic [BYTE_W-1:0] status_prev,
    input  logic              pend_prev,
    output logic [BYTE_W-1:0] ctl_next,
    output logic [BYTE_W-1:0] status_next,
    output logic              pend_next,
    output logic              emit
);
    always_comb begin
        ctl_next    = wdata | CONTROL_FORCE;
        status_next = status_prev;
        pend_next   = pend_prev;
        emit        = 1'b0;
        if (!ctl_next[CTL_INIT]) begin
            status_next = STATUS_IDLE;
        end else if (ctl_next[CTL_SELECT]) begin
            if (ctl_next[CTL_STROBE]) begin
                status_next[ST_BUSY] = 1'b0;
                emit                 = !prev_strobe;
            end else if (prev_irqen) begin
                pend_next = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpt_status_step.sv
module lpt_status_step
    import lpt_pkg::*;
(
    input  logic [BYTE_W-1:0] status_prev,
    input  logic              ctl_strobe,
    output logic [BYTE_W-1:0] status_next
);
    always_comb begin
        status_next = status_prev;
        if (!status_prev[ST_BUSY] && !ctl_strobe) begin
            if (status_prev[ST_ACK]) begin
                status_next[ST_ACK] = 1'b0;
            end else begin
                status_next[ST_ACK]  = 1'b1;
                status_next[ST_BUSY] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpt_read_mux.sv
module lpt_read_mux
    import lpt_pkg::*;
(
    input  logic [OFS_W-1:0]  offset,
    input  logic [BYTE_W-1:0] dataw,
    input  logic [BYTE_W-1:0] datar,
    input  logic [BYTE_W-1:0] status,
    input  logic [BYTE_W-1:0] control,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        case (offset)
            OFS_DATA:    rdata = control[CTL_DIR] ? datar : dataw;
            OFS_STATUS:  rdata = status;
            OFS_CONTROL: rdata = control;
            default:     rdata = OPEN_READ;
        endcase
    end
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs
    import lpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] port_din,
    output logic              irq,
    output logic              emit_valid,
    output logic [BYTE_W-1:0] emit_data
);
    regs_t regs_q, regs_d;

    logic [BYTE_W-1:0] wr_ctl, wr_status, rd_status;
    logic              wr_pend, wr_emit;

    lpt_ctrl_write u_ctrl_write (
        .wdata       (bus_wdata),
        .prev_strobe (regs_q.control[CTL_STROBE]),
        .prev_irqen  (regs_q.control[CTL_IRQEN]),
        .status_prev (regs_q.status),
        .pend_prev   (regs_q.pend),
        .ctl_next    (wr_ctl),
        .status_next (wr_status),
        .pend_next   (wr_pend),
        .emit        (wr_emit)
    );

    lpt_status_step u_status_step (
        .status_prev (regs_q.status),
        .ctl_strobe  (regs_q.control[CTL_STROBE]),
        .status_next (rd_status)
    );

    lpt_read_mux u_read_mux (
        .offset  (bus_addr),
        .dataw   (regs_q.dataw),
        .datar   (regs_q.datar),
        .status  (regs_q.status),
        .control (regs_q.control),
        .rdata   (bus_rdata)
    );

    always_comb begin
        regs_d            = regs_q;
        regs_d.emit_valid = 1'b0;
        if (regs_q.control[CTL_DIR]) begin
            regs_d.datar = port_din;
        end
        if (bus_sel) begin
            if (bus_wr) begin
                if (bus_addr == OFS_DATA) begin
                    regs_d.dataw = bus_wdata;
                end else if (bus_addr == OFS_CONTROL) begin
                    regs_d.control    = wr_ctl;
                    regs_d.status     = wr_status;
                    regs_d.pend       = wr_pend;
                    regs_d.emit_valid = wr_emit;
                    if (wr_emit) begin
                        regs_d.emit_data = regs_q.dataw;
                    end
                end
            end else if (bus_addr == OFS_STATUS) begin
                regs_d.status = rd_status;
                regs_d.pend   = 1'b0;
            end
            regs_d.irq = regs_d.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dataw      <= DATA_RST;
            regs_q.datar      <= DATA_RST;
            regs_q.status     <= STATUS_RST;
            regs_q.control    <= CONTROL_RST;
            regs_q.pend       <= 1'b0;
            regs_q.irq        <= 1'b0;
            regs_q.emit_valid <= 1'b0;
            regs_q.emit_data  <= DATA_RST;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign irq        = regs_q.irq;
    assign emit_valid = regs_q.emit_valid;
    assign emit_data  = regs_q.emit_data;
endmodule

// File: rtl/lpt_host_regs_chk.sv
module lpt_host_regs_chk
    import lpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [OFS_W-1:0]  bus_addr,
    input logic [BYTE_W-1:0] bus_rdata,
    input logic              irq,
    input logic              emit_valid
);
    logic ctl_wr, sts_rd;
    assign ctl_wr = bus_sel && bus_wr && (bus_addr == OFS_CONTROL);
    assign sts_rd = bus_sel && !bus_wr && (bus_addr == OFS_STATUS);

    AST_UNMAPPED_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 3'd3) |-> (bus_rdata == OPEN_READ)); // R1
    AST_CONTROL_TOP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_CONTROL) |-> (bus_rdata[7:6] == 2'b11)); // R2
    AST_EMIT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |=> !emit_valid); // R4
    AST_EMIT_FROM_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        emit_valid |-> $past(ctl_wr)); // R4
    AST_IRQ_RISE_FROM_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctl_wr)); // R5
    AST_IRQ_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(irq)); // R5
    AST_IRQ_CLEAR_ON_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rd |=> !irq); // R6
endmodule

bind lpt_host_regs lpt_host_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .emit_valid (emit_valid)
);

// File: tb/lpt_host_regs_tb_top.sv
module lpt_host_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [7:0] port_din = 8'd0;
    logic       irq, emit_valid;
    logic [7:0] emit_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lpt_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_din(port_din), .irq(irq), .emit_valid(emit_valid), .emit_data(emit_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset_values();
        logic [7:0] v;
        rd(3'd1, v); chk("R9 status", v, 8'hD9);
        rd(3'd2, v); chk("R9 control", v, 8'hCC);
        rd(3'd0, v); chk("R9 data", v, 8'hFF);
        chk("R9 irq", {7'd0, irq}, 8'h00);
        chk("R9 emit_valid", {7'd0, emit_valid}, 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] v;
        for (int a = 3; a < 8; a++) begin
            rd(3'(a), v); chk("R1 unmapped read", v, 8'hFF);
        end
        wr(3'd1, 8'h00);
        wr(3'd5, 8'h00);
        wr(3'd7, 8'h12);
        rd(3'd1, v); chk("R1 status after ignored writes", v, 8'hD9);
        rd(3'd2, v); chk("R1 control after ignored writes", v, 8'hCC);
        rd(3'd0, v); chk("R1 data after ignored writes", v, 8'hFF);
    endtask

    task automatic t_init();
        logic [7:0] v;
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R2 forced top bits", v, 8'hC0);
        rd(3'd1, v); chk("R3 init status", v, 8'hD8);
    endtask

    task automatic t_emit();
        logic [7:0] v;
        wr(3'd0, 8'h5A);
        wr(3'd2, 8'h0C);
        chk("R4 no emit on strobe low", {7'd0, emit_valid}, 8'h00);
        wr(3'd2, 8'h0D);
        chk("R4 emit valid", {7'd0, emit_valid}, 8'h01);
        chk("R4 emit data", emit_data, 8'h5A);
        @(negedge clk);
        chk("R4 pulse one cycle", {7'd0, emit_valid}, 8'h00);
        wr(3'd2, 8'h0D);
        chk("R4 no emit without edge", {7'd0, emit_valid}, 8'h00);
        wr(3'd0, 8'hA5);
        wr(3'd2, 8'h04);
        wr(3'd2, 8'h05);
        chk("R4 no emit without select", {7'd0, emit_valid}, 8'h00);
        rd(3'd1, v); chk("R4 busy cleared", v, 8'h58);
    endtask

    task automatic t_status_walk();
        logic [7:0] v;
        wr(3'd2, 8'h0C);
        rd(3'd1, v); chk("R7 walk 1", v, 8'h58);
        rd(3'd1, v); chk("R7 walk 2", v, 8'h18);
        rd(3'd1, v); chk("R7 walk 3", v, 8'hD8);
        rd(3'd1, v); chk("R7 walk stop", v, 8'hD8);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(3'd2, 8'h1C);
        chk("R5 enable not yet stored", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1C);
        chk("R5 irq raised", {7'd0, irq}, 8'h01);
        wr(3'd0, 8'h11);
        chk("R5 irq held", {7'd0, irq}, 8'h01);
        rd(3'd1, v);
        chk("R6 irq cleared by status read", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h0C);
        chk("R5 stored enable used", {7'd0, irq}, 8'h01);
        wr(3'd2, 8'h0C);
        chk("R5 pending kept", {7'd0, irq}, 8'h01);
        rd(3'd1, v);
        chk("R6 irq cleared again", {7'd0, irq}, 8'h00);
        wr(3'd2, 8'h1D);
        chk("R5 no irq on strobe high", {7'd0, irq}, 8'h00);
        chk("R4 emit after irq case", emit_data, 8'h11);
    endtask

    task automatic t_direction();
        logic [7:0] v;
        port_din = 8'h3C;
        wr(3'd2, 8'h2C);
        rd(3'd2, v); chk("R2 control with dir", v, 8'hEC);
        rd(3'd0, v); chk("R8 read latch", v, 8'h3C);
        port_din = 8'hC3;
        rd(3'd0, v); chk("R8 read latch follows", v, 8'hC3);
        wr(3'd2, 8'h0C);
        rd(3'd0, v); chk("R8 write byte when dir clear", v, 8'h11);
    endtask

    initial begin
        do_reset();
        t_reset_values();
        t_decode();
        t_init();
        t_emit();
        t_status_walk();
        t_irq();
        t_direction();
        do_reset();
        t_reset_values();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule